// File: doc/BRIEF.md
# DRAM Burst Column Address Sequencer

This block produces the column addresses that a DRAM controller sends with each data beat of a read or write burst. A one-cycle start strobe carries three things: the first column, a length select (4 or 8 beats) and an order select (sequential or interleaved). From the next cycle on, the block issues one column per clock together with a valid flag. A last-beat flag marks the final address.

The burst stays inside an aligned block of columns. The length sets the block size: 4 or 8 columns. The low two bits (BL4) or three bits (BL8) of the start column give the position inside that block, and all higher bits are held for the whole burst. In sequential order the in-block offset counts up by one and wraps at the block boundary. In interleaved order the offset for beat i is the start offset XOR i. A start strobe is ignored while a burst is running, except on the cycle of its final beat. On that cycle a new burst may follow with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high and after it falls, `beat_vld_o` and `last_o` are 0 and `col_o` is 0 until a start is accepted.
- R2: An accepted strobe on `start_i` makes `beat_vld_o` high from the next cycle on. The first `col_o` equals `start_col_i`. Beats follow on consecutive cycles: 8 beats when `bl8_i` is 1, 4 beats when it is 0.
- R3: With `ileave_i` = 0 (sequential), the in-block offset of beat i is (start offset + i) modulo the burst length.
- R4: With `ileave_i` = 1 (interleaved), the in-block offset of beat i is the start offset XOR i.
- R5: The in-block offset is `col_o[1:0]` for BL4 and `col_o[2:0]` for BL8. Every higher bit of `col_o` equals the start column for the whole burst.
- R6: `last_o` is high only on the final beat of a burst. If no new start is accepted on that cycle, `beat_vld_o` is 0 on the cycle after it.
- R7: A strobe on `start_i` during a burst, on any beat but the last, has no effect. The running burst keeps its addresses, its order and its length.
- R8: A strobe on `start_i` during the final beat starts the new burst on the very next cycle, with no idle beat between the two bursts.
- R9: `bl8_i`, `ileave_i` and `start_col_i` are sampled only when a start is accepted. Changing them during a burst has no effect on it.
- R10: With a start offset of zero, sequential and interleaved bursts produce identical column sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst start strobe |
| start_col_i | input | COL_W | First column of the burst |
| bl8_i | input | 1 | Burst length select: 1 = eight beats, 0 = four beats |
| ileave_i | input | 1 | Order select: 1 = interleaved, 0 = sequential |
| beat_vld_o | output | 1 | A column address is being issued this cycle |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
The embedded assertions check, on every cycle, several beat-to-beat relations:
- the first beat of an accepted burst carries the strobed column;
- the upper column bits do not move during a burst;
- a sequential offset steps by one modulo the block size;
- an interleaved step onto an odd beat flips only the lowest bit;
- the last-beat flag appears only at the final beat index;
- a strobe during a busy, non-final beat never restarts the burst.

Only the bench's scenarios can show that complete sequences match the expected orders for each start offset, length and type. The same holds for mid-burst changes of the select inputs having no effect, for back-to-back bursts running without a gap, and for the valid flag dropping after the final beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  // Widest in-block offset: an eight-beat block needs three bits.
  localparam int unsigned OFS_W = 3;
  localparam int unsigned BL4_OFS_W = 2;

  localparam logic [OFS_W-1:0] FINAL_BL4 = 3'd3;
  localparam logic [OFS_W-1:0] FINAL_BL8 = 3'd7;

  typedef logic [OFS_W-1:0] beat_t;

  function automatic beat_t final_beat(input logic bl8);
    return bl8 ? FINAL_BL8 : FINAL_BL4;
  endfunction
endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import burst_col_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_i,
  input  logic  bl8_i,
  output logic  accept_o,
  output logic  active_o,
  output logic  first_o,
  output logic  last_o,
  output logic  bl8_o,
  output beat_t beat_o,
  output beat_t beat_nxt_o
);
  logic  active_q, first_q, last_q, bl8_q;
  beat_t beat_q;
  beat_t beat_inc;

  // A strobe is taken when idle, or on the final beat for a seamless follow-on burst.
  assign accept_o   = start_i && (!active_q || last_q);
  assign beat_inc   = beat_t'(beat_q + 3'd1);
  assign beat_nxt_o = accept_o ? '0 : beat_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      bl8_q    <= 1'b0;
      beat_q   <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      first_q  <= 1'b1;
      last_q   <= 1'b0;
      bl8_q    <= bl8_i;
      beat_q   <= '0;
    end else if (active_q) begin
      first_q <= 1'b0;
      if (last_q) begin
        active_q <= 1'b0;
        last_q   <= 1'b0;
      end else begin
        beat_q <= beat_inc;
        last_q <= (beat_inc == final_beat(bl8_q));
      end
    end
  end

  assign active_o = active_q;
  assign first_o  = first_q;
  assign last_o   = last_q;
  assign bl8_o    = bl8_q;
  assign beat_o   = beat_q;

  // R6: the last flag appears only at the final beat index of the held length
  a_r6_last_at_final: assert property (@(posedge clk) disable iff (rst)
    last_q |-> (active_q && beat_q == final_beat(bl8_q)));

  // R2: beats after the first advance by exactly one per cycle
  a_r2_beat_step: assert property (@(posedge clk) disable iff (rst)
    (active_q && !first_q) |-> (beat_q == beat_t'($past(beat_q) + 3'd1)));

  // R7: a strobe on a busy, non-final beat does not restart the burst
  a_r7_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (start_i && active_q && !last_q) |=> !first_q);
endmodule

// File: rtl/bsq_offset_gen.sv
module bsq_offset_gen
  import burst_col_pkg::*;
(
  input  beat_t start_ofs_i,
  input  beat_t beat_i,
  input  logic  bl8_i,
  input  logic  ileave_i,
  output beat_t ofs_o
);
  beat_t seq_ofs, ilv_ofs, mix;

  assign seq_ofs = beat_t'(start_ofs_i + beat_i);
  assign ilv_ofs = start_ofs_i ^ beat_i;
  assign mix     = ileave_i ? ilv_ofs : seq_ofs;

  // Bits inside the block come from the order logic; bit 2 passes the start column for BL4.
  for (genvar k = 0; k < OFS_W; k++) begin : g_bit
    if (k < BL4_OFS_W) begin : g_inner
      assign ofs_o[k] = mix[k];
    end else begin : g_outer
      assign ofs_o[k] = bl8_i ? mix[k] : start_ofs_i[k];
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             bl8_i,
  input  logic             ileave_i,
  output logic             beat_vld_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  localparam int unsigned HI_W = COL_W - OFS_W;

  logic             accept, active, first, last, bl8_q;
  beat_t            beat, beat_nxt;
  logic [COL_W-1:0] base_q, base_nxt;
  logic             ilv_q, ilv_nxt, bl8_nxt;
  beat_t            ofs_nxt;
  logic [COL_W-1:0] col_q;

  bsq_beat_ctr u_ctr (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .bl8_i      (bl8_i),
    .accept_o   (accept),
    .active_o   (active),
    .first_o    (first),
    .last_o     (last),
    .bl8_o      (bl8_q),
    .beat_o     (beat),
    .beat_nxt_o (beat_nxt)
  );

  // Burst attributes as seen by the next beat: fresh inputs on accept, held copies otherwise.
  assign base_nxt = accept ? start_col_i : base_q;
  assign ilv_nxt  = accept ? ileave_i    : ilv_q;
  assign bl8_nxt  = accept ? bl8_i       : bl8_q;

  bsq_offset_gen u_ofs (
    .start_ofs_i (base_nxt[OFS_W-1:0]),
    .beat_i      (beat_nxt),
    .bl8_i       (bl8_nxt),
    .ileave_i    (ilv_nxt),
    .ofs_o       (ofs_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ilv_q  <= 1'b0;
      col_q  <= '0;
    end else begin
      if (accept) begin
        base_q <= start_col_i;
        ilv_q  <= ileave_i;
      end
      if (accept || (active && !last)) begin
        col_q <= {base_nxt[COL_W-1:OFS_W], ofs_nxt};
      end
    end
  end

  assign beat_vld_o = active;
  assign col_o      = col_q;
  assign last_o     = last;

  // R2: the first beat of an accepted burst carries the strobed column
  a_r2_first_col: assert property (@(posedge clk) disable iff (rst)
    accept |=> (beat_vld_o && first && col_o == $past(start_col_i)));

  // R5: bits above the eight-beat block never move inside a burst
  a_r5_upper_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !first) |-> (col_o[COL_W-1:OFS_W] == $past(col_o[COL_W-1:OFS_W])));

  // R5: for four-beat bursts bit 2 also stays put
  a_r5_bl4_bit2: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !first && !bl8_q) |-> (col_o[2] == $past(col_o[2])));

  // R3: sequential eight-beat offset steps by one modulo eight
  a_r3_seq_bl8: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !first && !ilv_q && bl8_q) |-> (col_o[2:0] == 3'($past(col_o[2:0]) + 3'd1)));

  // R3: sequential four-beat offset steps by one modulo four
  a_r3_seq_bl4: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !first && !ilv_q && !bl8_q) |-> (col_o[1:0] == 2'($past(col_o[1:0]) + 2'd1)));

  // R4: interleaved step onto an odd beat flips only bit 0
  a_r4_ilv_odd: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !first && ilv_q && beat[0]) |->
      (col_o[2:1] == $past(col_o[2:1]) && col_o[0] != $past(col_o[0])));

  // R6: the last flag implies a valid beat
  a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
    last_o |-> beat_vld_o);

  // R1: nothing valid right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!beat_vld_o && !last_o));

  initial begin
    assert (COL_W > OFS_W) else $error("COL_W must exceed the offset width");
  end

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 10;

  typedef struct packed {
    logic             bl8;
    logic             ilv;
    logic [COL_W-1:0] col;
    logic [0:7][2:0]  ofs;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 10'h0AD, {3'd5,3'd6,3'd7,3'd0,3'd1,3'd2,3'd3,3'd4}},  // R3
    '{1'b1, 1'b1, 10'h0AB, {3'd3,3'd2,3'd1,3'd0,3'd7,3'd6,3'd5,3'd4}},  // R4
    '{1'b0, 1'b1, 10'h0F1, {3'd1,3'd0,3'd3,3'd2,3'd0,3'd0,3'd0,3'd0}},  // R4
    '{1'b0, 1'b0, 10'h3FE, {3'd2,3'd3,3'd0,3'd1,3'd0,3'd0,3'd0,3'd0}},  // R3 R5
    '{1'b1, 1'b0, 10'h000, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}},  // R10
    '{1'b1, 1'b1, 10'h000, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}},  // R10
    '{1'b0, 1'b1, 10'h13F, {3'd3,3'd2,3'd1,3'd0,3'd0,3'd0,3'd0,3'd0}},  // R4 R5
    '{1'b1, 1'b1, 10'h2B6, {3'd6,3'd7,3'd4,3'd5,3'd2,3'd3,3'd0,3'd1}},  // R4
    '{1'b1, 1'b0, 10'h207, {3'd7,3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6}},  // R3
    '{1'b0, 1'b0, 10'h001, {3'd1,3'd2,3'd3,3'd0,3'd0,3'd0,3'd0,3'd0}},  // R3
    '{1'b1, 1'b1, 10'h1F5, {3'd5,3'd4,3'd7,3'd6,3'd1,3'd0,3'd3,3'd2}},  // R4
    '{1'b0, 1'b1, 10'h004, {3'd0,3'd1,3'd2,3'd3,3'd0,3'd0,3'd0,3'd0}}   // R10 R5
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic             bl8_i = 1'b0;
  logic             ileave_i = 1'b0;
  logic             beat_vld_o, last_o;
  logic [COL_W-1:0] col_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .bl8_i(bl8_i), .ileave_i(ileave_i),
    .beat_vld_o(beat_vld_o), .col_o(col_o), .last_o(last_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] exp_col(input logic bl8, input logic [COL_W-1:0] c,
                                               input logic [2:0] o);
    return bl8 ? {c[COL_W-1:3], o} : {c[COL_W-1:2], o[1:0]};
  endfunction

  // One beat checked at a negedge: valid, column and last flag.
  task automatic check_beat(input string req, input logic bl8, input logic [COL_W-1:0] c,
                            input logic [2:0] o, input int b);
    int n;
    n = bl8 ? 8 : 4;
    check({req, " valid"}, 32'(beat_vld_o), 32'd1);
    check({req, " col"},   32'(col_o), 32'(exp_col(bl8, c, o)));
    check("R6 last flag",  32'(last_o), 32'(b == n - 1));
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    n = v.bl8 ? 8 : 4;
    @(negedge clk);
    start_i = 1'b1; bl8_i = v.bl8; ileave_i = v.ilv; start_col_i = v.col;
    @(negedge clk);
    // R9: scramble the selects right after the strobe
    start_i = 1'b0; bl8_i = ~v.bl8; ileave_i = ~v.ilv; start_col_i = ~v.col;
    for (int b = 0; b < n; b++) begin
      check_beat(v.ilv ? "R4 R9" : "R3 R9", v.bl8, v.col, v.ofs[b], b);
      @(negedge clk);
    end
    check("R6 idle after last", 32'(beat_vld_o), 32'd0);
    check("R2 burst length", 32'(last_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(beat_vld_o), 32'd0);
    check("R1 reset last",  32'(last_o), 32'd0);
    check("R1 reset col",   32'(col_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", 32'(beat_vld_o), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7: strobe on beat 2 of a BL8 sequential burst is ignored
    @(negedge clk);
    start_i = 1'b1; bl8_i = 1'b1; ileave_i = 1'b0; start_col_i = 10'h010;
    @(negedge clk);
    start_i = 1'b0;
    for (int b = 0; b < 8; b++) begin
      check_beat("R7", 1'b1, 10'h010, 3'(b), b);
      if (b == 2) begin
        start_i = 1'b1; start_col_i = 10'h3FF; bl8_i = 1'b0; ileave_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    check("R7 no restart", 32'(beat_vld_o), 32'd0);

    // R8: strobe on the final beat starts the next burst with no gap
    start_i = 1'b1; bl8_i = 1'b0; ileave_i = 1'b0; start_col_i = 10'h020;
    @(negedge clk);
    start_i = 1'b0;
    for (int b = 0; b < 4; b++) begin
      check_beat("R8 first burst", 1'b0, 10'h020, 3'(b), b);
      if (b == 3) begin
        start_i = 1'b1; bl8_i = 1'b1; ileave_i = 1'b1; start_col_i = 10'h0C6;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check_beat("R8 back-to-back", 1'b1, 10'h0C6, 3'd6, 0);
    @(negedge clk);
    check_beat("R8 second beat", 1'b1, 10'h0C6, 3'd7, 1);

    // R1: reset in mid-burst returns to idle
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-burst reset valid", 32'(beat_vld_o), 32'd0);
    check("R1 mid-burst reset col",   32'(col_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule